// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by fetching page table entries from memory. A walk starts from a 20-bit virtual page number and a directory base address. The walker fetches the first-level (directory) entry, uses it to find a second-level table, fetches the leaf entry there, and returns that leaf so the translation cache can be refilled. If the directory entry is absent, the walk stops at once and reports a fault. If the leaf entry is absent, the walk also reports a fault, so that software can load the missing table or page.

The page number is split into two 10-bit indices, one for the directory and one for the table. Each table holds 1024 four-byte entries, so one table fills exactly one 4 KB page. Memory is reached through a read port that works by request and response. A request is held until it is granted, and the data comes back a variable number of cycles later. Only one walk runs at a time. Directory entries are never delivered as results; only the leaf is.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, `walk_busy`, `mem_req`, `res_valid` and `res_fault` are all 0.
- R2: A `walk_req` seen while idle is accepted. `walk_busy` is 1 from the cycle after acceptance through the cycle that carries the result, and 0 in the cycle after that.
- R3: A `walk_req` raised while `walk_busy` is 1 is ignored. It causes no memory read and no result, and it does not disturb the walk in flight.
- R4: The directory read address is `dir_base + 4 * walk_vpn[19:10]`, computed as a full 32-bit sum.
- R5: The leaf read address is the concatenation of directory entry bits 31..12, `walk_vpn[9:0]` and `2'b00`. A successful walk makes exactly two reads.
- R6: `mem_req` stays high with an unchanging `mem_addr` until `mem_gnt`. Only one read is outstanding at a time. A response is taken only on `mem_rvalid` after a grant.
- R7: An entry whose bit 0 (valid) is 0 counts as absent. An absent directory entry ends the walk after one read, with `res_fault`=1, `res_fault_lvl`=0 and `res_pte` equal to that entry.
- R8: An absent leaf entry gives `res_fault`=1, `res_fault_lvl`=1 and `res_pte` equal to that leaf entry.
- R9: A present leaf gives `res_valid`=1 with `res_pte` equal to the leaf word, unchanged. This includes bit 1 (write enable) and bits 31..12 (physical page number).
- R10: The result appears in the cycle after the response to the last read is taken. With grant delay g and response latency L, this is n*(g+1+L) clock edges after the accepting edge, where n is 1 for a directory fault and 2 otherwise.
- R11: `res_valid` and `res_fault` are never high together. Each is a one-cycle pulse, followed by an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| walk_req | input | 1 | Start a walk (ignored while busy) |
| walk_vpn | input | 20 | Virtual page number to translate |
| dir_base | input | 32 | Physical byte address of the directory table |
| walk_busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Read request to memory |
| mem_addr | output | 32 | Read byte address |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| res_valid | output | 1 | Leaf entry delivered for refill |
| res_fault | output | 1 | Walk ended in a page fault |
| res_fault_lvl | output | 1 | Fault level: 0 directory, 1 leaf |
| res_pte | output | 32 | Leaf entry, or the absent entry on a fault |

## Verification
Each result is due n*(g+1+L) edges after the accepting edge. Here n is the number of reads, g the grant delay and L the response latency, both set by the memory model. The driver records the accepting edge together with n, g and L at the time it queues the expected item. The monitor then requires the result in exactly that cycle. Reads are counted per walk, and every requested address is compared against a queue of expected addresses in each cycle the request is held. Results and the busy flag are sampled on the falling edge, which is half a period after the register that drives them updates.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    // Walk controller states; the order is not decoded anywhere else
    typedef enum logic [2:0] {
        WS_IDLE,
        WS_READ_L1,
        WS_WAIT_L1,
        WS_READ_L2,
        WS_WAIT_L2,
        WS_DONE,
        WS_FAULT
    } walk_state_e;

    // Level at which a walk stopped; encoded 0 = directory, 1 = leaf
    typedef enum logic {
        LVL_DIR  = 1'b0,
        LVL_LEAF = 1'b1
    } walk_level_e;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int XLEN         = 32,
    parameter int PAGE_OFS     = 12,
    parameter int IDX_W        = 10,
    parameter bit BASE_ALIGNED = 1'b0
) (
    input  logic [2*IDX_W-1:0]       vpn,
    input  logic [XLEN-1:0]          dir_base,
    input  logic [XLEN-PAGE_OFS-1:0] l1_ppn,
    input  logic                     sel_leaf,
    output logic [XLEN-1:0]          entry_addr
);
    localparam int ENT_LOG2 = PAGE_OFS - IDX_W;
    localparam int PAD_W    = XLEN - IDX_W - ENT_LOG2;

    logic [IDX_W-1:0] idx_dir;
    logic [IDX_W-1:0] idx_leaf;
    logic [XLEN-1:0]  dir_addr;
    logic [XLEN-1:0]  leaf_addr;

    assign idx_dir  = vpn[2*IDX_W-1:IDX_W];
    assign idx_leaf = vpn[IDX_W-1:0];

    // Directory entry address: a page-aligned base can be spliced, otherwise a full add
    generate
        if (BASE_ALIGNED) begin : g_splice
            assign dir_addr = {dir_base[XLEN-1:PAGE_OFS], idx_dir, {ENT_LOG2{1'b0}}};
        end else begin : g_add
            assign dir_addr = dir_base + {{PAD_W{1'b0}}, idx_dir, {ENT_LOG2{1'b0}}};
        end
    endgenerate

    // Leaf table always starts on a page boundary given by the directory entry
    assign leaf_addr  = {l1_ppn, idx_leaf, {ENT_LOG2{1'b0}}};
    assign entry_addr = sel_leaf ? leaf_addr : dir_addr;

endmodule

// File: rtl/ptw_rd_tracker.sv
module ptw_rd_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic mem_req,
    input  logic mem_gnt,
    input  logic mem_rvalid,
    output logic rsp_take
);
    logic out_d;
    logic out_q;

    always_comb begin
        out_d = out_q;
        if (mem_req && mem_gnt) begin
            out_d = 1'b1;
        end else if (mem_rvalid && out_q) begin
            out_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    // Data is accepted only for a read that was granted and not yet answered
    assign rsp_take = mem_rvalid && out_q;

    // R6: no new request while a read is outstanding
    a_r6_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        out_q |-> !mem_req);

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int XLEN         = 32,
    parameter int PAGE_OFS     = 12,
    parameter int IDX_W        = 10,
    parameter int VALID_BIT    = 0,
    parameter bit BASE_ALIGNED = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 walk_req,
    input  logic [2*IDX_W-1:0]   walk_vpn,
    input  logic [XLEN-1:0]      dir_base,
    output logic                 walk_busy,
    output logic                 mem_req,
    output logic [XLEN-1:0]      mem_addr,
    input  logic                 mem_gnt,
    input  logic                 mem_rvalid,
    input  logic [XLEN-1:0]      mem_rdata,
    output logic                 res_valid,
    output logic                 res_fault,
    output logic                 res_fault_lvl,
    output logic [XLEN-1:0]      res_pte
);
    localparam int VPN_W = 2 * IDX_W;
    localparam int PPN_W = XLEN - PAGE_OFS;

    typedef struct packed {
        walk_state_e          st;
        logic [VPN_W-1:0]     vpn;
        logic [XLEN-1:0]      base;
        logic [XLEN-1:0]      entry;
        walk_level_e          lvl;
    } walk_regs_t;

    localparam walk_regs_t REGS_RST = '{
        st:    WS_IDLE,
        vpn:   '0,
        base:  '0,
        entry: '0,
        lvl:   LVL_DIR
    };

    walk_regs_t r_d;
    walk_regs_t r_q;
    logic       rsp_take;
    logic       sel_leaf;
    logic       rd_present;

    assign rd_present = mem_rdata[VALID_BIT];
    assign sel_leaf   = (r_q.st == WS_READ_L2);

    ptw_addr_gen #(
        .XLEN         (XLEN),
        .PAGE_OFS     (PAGE_OFS),
        .IDX_W        (IDX_W),
        .BASE_ALIGNED (BASE_ALIGNED)
    ) u_addr_gen (
        .vpn        (r_q.vpn),
        .dir_base   (r_q.base),
        .l1_ppn     (r_q.entry[XLEN-1:XLEN-PPN_W]),
        .sel_leaf   (sel_leaf),
        .entry_addr (mem_addr)
    );

    ptw_rd_tracker u_rd_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_req    (mem_req),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .rsp_take   (rsp_take)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            WS_IDLE: begin
                if (walk_req) begin
                    r_d.st   = WS_READ_L1;
                    r_d.vpn  = walk_vpn;
                    r_d.base = dir_base;
                end
            end
            WS_READ_L1: begin
                if (mem_gnt) r_d.st = WS_WAIT_L1;
            end
            WS_WAIT_L1: begin
                if (rsp_take) begin
                    r_d.entry = mem_rdata;
                    r_d.lvl   = LVL_DIR;
                    r_d.st    = rd_present ? WS_READ_L2 : WS_FAULT;
                end
            end
            WS_READ_L2: begin
                if (mem_gnt) r_d.st = WS_WAIT_L2;
            end
            WS_WAIT_L2: begin
                if (rsp_take) begin
                    r_d.entry = mem_rdata;
                    r_d.lvl   = LVL_LEAF;
                    r_d.st    = rd_present ? WS_DONE : WS_FAULT;
                end
            end
            WS_DONE:  r_d.st = WS_IDLE;
            WS_FAULT: r_d.st = WS_IDLE;
            default:  r_d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign walk_busy     = (r_q.st != WS_IDLE);
    assign mem_req       = (r_q.st == WS_READ_L1) || (r_q.st == WS_READ_L2);
    assign res_valid     = (r_q.st == WS_DONE);
    assign res_fault     = (r_q.st == WS_FAULT);
    assign res_fault_lvl = r_q.lvl;
    assign res_pte       = r_q.entry;

    // R6: a pending request keeps its address until granted
    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    // R2: memory is only requested inside a walk
    a_r2_req_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> walk_busy);

    // R3: the captured page number is not overwritten during a walk
    a_r3_vpn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != WS_IDLE) |=> ((r_q.st == WS_IDLE) || $stable(r_q.vpn)));

    // R11: results are exclusive
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && res_fault));

    // R11: one-cycle result followed by idle
    a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid || res_fault) |=> (!res_valid && !res_fault && !walk_busy));

    // R9: a delivered leaf is always marked present
    a_r9_leaf_present: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_pte[VALID_BIT]);

    // R7: a faulting entry is always marked absent
    a_r7_fault_absent: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> !res_pte[VALID_BIT]);

endmodule

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        walk_req;
    logic [19:0] walk_vpn;
    logic [31:0] dir_base;
    logic        walk_busy, mem_req, mem_gnt, mem_rvalid;
    logic [31:0] mem_addr, mem_rdata;
    logic        res_valid, res_fault, res_fault_lvl;
    logic [31:0] res_pte;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_walker u_ptw_walker (
        .clk(clk), .rst_n(rst_n), .walk_req(walk_req), .walk_vpn(walk_vpn),
        .dir_base(dir_base), .walk_busy(walk_busy), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .res_valid(res_valid), .res_fault(res_fault),
        .res_fault_lvl(res_fault_lvl), .res_pte(res_pte)
    );

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int nreads = 0;
    int nres = 0;
    int nstart = 0;
    int gd = 0;
    int lat = 1;

    logic [31:0] mem_img [bit [31:0]];

    function automatic logic [31:0] peek(input logic [31:0] a);
        if (mem_img.exists(a)) return mem_img[a];
        return 32'h0;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Memory model: grant after gd waiting cycles, data lat cycles after grant
    int gcnt = 0;
    int rcnt = 0;
    logic [31:0] rdata_q = '0;
    assign mem_gnt    = mem_req && (gcnt >= gd);
    assign mem_rvalid = (rcnt == 1);
    assign mem_rdata  = rdata_q;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            gcnt <= 0;
            rcnt <= 0;
        end else begin
            if (mem_req && !mem_gnt) gcnt <= gcnt + 1;
            else gcnt <= 0;
            if (mem_req && mem_gnt) begin
                rcnt    <= lat;
                rdata_q <= peek(mem_addr);
                nreads  <= nreads + 1;
            end else if (rcnt != 0) begin
                rcnt <= rcnt - 1;
            end
        end
    end

    typedef struct {
        logic [31:0] a;
        bit          leaf;
    } addr_t;

    typedef struct {
        bit          is_fault;
        bit          lvl;
        logic [31:0] pte;
        int          due;
        int          rd0;
        int          nrd;
    } exp_t;

    addr_t aq[$];
    exp_t  sbq[$];

    // Address monitor: R4/R5 on each requested address, R6 while held
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (aq.size() == 0) begin
                chk(1'b0, "R3", "unexpected read", mem_addr, 32'h0);
            end else begin
                chk(mem_addr == aq[0].a, mem_gnt ? (aq[0].leaf ? "R5" : "R4") : "R6",
                    "read address", mem_addr, aq[0].a);
                if (mem_gnt) void'(aq.pop_front());
            end
        end
    end

    // Result monitor / scoreboard
    bit after = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (after) begin
                chk(!(res_valid || res_fault) && !walk_busy, "R11", "idle after result",
                    {29'b0, res_valid, res_fault, walk_busy}, 32'h0);
                after = 1'b0;
            end
            if (res_valid || res_fault) begin
                nres++;
                after = 1'b1;
                chk(!(res_valid && res_fault), "R11", "exclusive", {30'b0, res_valid, res_fault}, 32'h2);
                chk(walk_busy, "R2", "busy in result cycle", {31'b0, walk_busy}, 32'h1);
                if (sbq.size() == 0) begin
                    chk(1'b0, "R3", "result with no walk", res_pte, 32'h0);
                end else begin
                    exp_t e;
                    string tg;
                    e  = sbq.pop_front();
                    tg = !e.is_fault ? "R9" : (e.lvl ? "R8" : "R7");
                    chk(res_fault == e.is_fault, tg, "fault flag", {31'b0, res_fault}, {31'b0, e.is_fault});
                    chk(res_pte == e.pte, tg, "entry", res_pte, e.pte);
                    if (e.is_fault)
                        chk(res_fault_lvl == e.lvl, tg, "fault level", {31'b0, res_fault_lvl}, {31'b0, e.lvl});
                    chk(cyc == e.due, "R10", "result cycle", cyc, e.due);
                    chk(nreads - e.rd0 == e.nrd, (e.is_fault && !e.lvl) ? "R7" : "R5",
                        "read count", nreads - e.rd0, e.nrd);
                end
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (walk_busy) @(negedge clk);
    endtask

    task automatic set_timing(input int g, input int l);
        wait_idle();
        gd  = g;
        lat = l;
    endtask

    // Driver: computes the expected walk from the table image, then starts it
    task automatic start_walk(input logic [19:0] vpn, input logic [31:0] base);
        exp_t e;
        logic [31:0] a1, d1, a2, d2;
        wait_idle();
        a1 = base + {20'b0, vpn[19:10], 2'b00};
        d1 = peek(a1);
        aq.push_back('{a: a1, leaf: 1'b0});
        e.nrd = 1;
        e.is_fault = 1'b1;
        e.lvl = 1'b0;
        e.pte = d1;
        if (d1[0]) begin
            a2 = {d1[31:12], vpn[9:0], 2'b00};
            d2 = peek(a2);
            aq.push_back('{a: a2, leaf: 1'b1});
            e.nrd = 2;
            e.is_fault = !d2[0];
            e.lvl = 1'b1;
            e.pte = d2;
        end
        walk_req = 1'b1;
        walk_vpn = vpn;
        dir_base = base;
        @(negedge clk);
        walk_req = 1'b0;
        e.due = cyc + e.nrd * (gd + 1 + lat);
        e.rd0 = nreads;
        sbq.push_back(e);
        nstart++;
        chk(walk_busy, "R2", "busy after accept", {31'b0, walk_busy}, 32'h1);
    endtask

    task automatic map_dir(input logic [31:0] base, input logic [9:0] i1, input logic [31:0] ent);
        mem_img[base + {20'b0, i1, 2'b00}] = ent;
    endtask

    task automatic map_leaf(input logic [19:0] ppn, input logic [9:0] i2, input logic [31:0] ent);
        mem_img[{ppn, i2, 2'b00}] = ent;
    endtask

    localparam logic [31:0] B1 = 32'h0001_0000;
    localparam logic [31:0] B2 = 32'h0020_0004;

    initial begin
        rst_n    = 1'b0;
        walk_req = 1'b0;
        walk_vpn = '0;
        dir_base = '0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk({walk_busy, mem_req, res_valid, res_fault} == 4'b0, "R1", "in reset",
            {28'b0, walk_busy, mem_req, res_valid, res_fault}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({walk_busy, mem_req, res_valid, res_fault} == 4'b0, "R1", "after reset",
            {28'b0, walk_busy, mem_req, res_valid, res_fault}, 32'h0);

        map_dir(B1, 10'h001, 32'h0003_0001);
        map_leaf(20'h00030, 10'h002, 32'hABCD_E003);
        map_leaf(20'h00030, 10'h011, 32'hFFFF_F002);
        map_leaf(20'h00030, 10'h020, 32'h0BAD_0001);
        map_dir(B1, 10'h006, 32'h0000_5000);
        map_dir(B1, 10'h007, 32'h0004_0003);
        map_leaf(20'h00040, 10'h000, 32'h7777_7001);
        map_dir(B2, 10'h3FF, 32'h0005_0001);
        map_leaf(20'h00050, 10'h3FF, 32'h1234_5001);

        // R9: present leaf with write-enable, fastest memory
        set_timing(0, 1);
        start_walk({10'h001, 10'h002}, B1);
        // R4/R9: unaligned base with carry, both indices at maximum, slow memory
        set_timing(2, 3);
        start_walk({10'h3FF, 10'h3FF}, B2);
        // R7: null directory entry, then absent non-zero directory entry
        start_walk({10'h005, 10'h000}, B1);
        start_walk({10'h006, 10'h001}, B1);
        // R8: unmapped leaf, then leaf with write bit but no valid bit
        set_timing(1, 2);
        start_walk({10'h001, 10'h010}, B1);
        start_walk({10'h001, 10'h011}, B1);
        // R3: a request during a walk is ignored
        set_timing(1, 4);
        start_walk({10'h007, 10'h000}, B1);
        @(negedge clk);
        walk_req = 1'b1;
        walk_vpn = {10'h001, 10'h020};
        dir_base = B1;
        @(negedge clk);
        walk_req = 1'b0;
        // R10: back-to-back walks
        set_timing(0, 1);
        start_walk({10'h001, 10'h002}, B1);
        start_walk({10'h007, 10'h000}, B1);

        wait_idle();
        repeat (10) @(negedge clk);
        chk(sbq.size() == 0 && nres == nstart, "R3", "result count", nres, nstart);
        chk(aq.size() == 0, "R6", "pending addresses", aq.size(), 32'h0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL R10 watchdog expired: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule